// File: doc/BRIEF.md
# Hardware-request transfer start sequencer

This block decides when a peripheral request line may start a descriptor-driven transfer in a DMA-style controller with `N_CH` hardware channels. Each request pulse is latched as pending. A pending channel may start only while its enable input is high, its mask flag is clear and the global stop flag is clear. When several channels qualify, the lowest index starts first. The other channels stay pending until the running transfer has finished.

On each hardware start, the block copies the channel's descriptor pointer register into a one-entry pointer buffer. If the same channel runs again and the buffer is still valid, the copy is skipped, so a chained pointer left behind by an earlier transfer is reused. The buffer is offered to an external execution engine over a valid/ready start handshake. The engine then reports one outcome pulse: normal end, chain, or error.

The block turns that outcome into the following actions:
- a re-issue at once when the chain is locked;
- a per-channel interrupt flag;
- a per-channel mask plus a sticky one-entry error record with a double-error bit;
- optionally, the global stop.

A software request path outranks the next hardware start, and its errors are recorded the same way.

Top module: `hss_top`

## Requirements
- R1: A hardware channel starts only when all of these hold: a request pulse has been latched for it, `ch_enable[n]`=1, `mask_flags[n]`=0 and `stop_flag`=0. A channel that fails these conditions stays pending and starts once they hold.
- R2: Among qualifying channels, the lowest index starts first. The others remain pending and start in ascending order in later transfers.
- R3: On a hardware start, `eng_ptr` equals the channel's pointer register. The exception is when the channel equals the one held in the pointer buffer and the buffer is valid: then the buffered value is offered. Writing the pointer register of the buffered channel invalidates the buffer.
- R4: A chain outcome on a hardware transfer loads `done_chain_ptr` into the pointer buffer. If `done_chain_lock`=1, the same channel (or the software transfer) is offered again on the next cycle with the new pointer, ahead of any pending request.
- R5: A non-error outcome with `done_irq`=1 sets `irq_flags[n]` of the running hardware channel. An error outcome never sets it.
- R6: An error outcome on hardware channel n sets `mask_flags[n]`, which blocks its later starts.
- R7: When the error record is empty, an error fills it (`err_valid`=1, `err_ch`, `err_sw`, `err_info`). When a record already exists, only `err_double` is set and the stored fields are kept.
- R8: When `cfg_stop_on_err`=1, an error outcome sets `stop_flag`. While `stop_flag`=1, no hardware or software start is offered.
- R9: When `sw_req`=1 and a hardware channel also qualifies, the software transfer starts first, with `eng_sw`=1 and `eng_ptr`=`sw_ptr`. A software error is recorded with `err_sw`=1 and does not change any mask flag.
- R10: `mask_clr`, `irq_clr`, `err_clr` (record and double bit) and `stop_clr` clear their flags; otherwise the flags hold their values until reset.
- R11: Once `eng_valid` rises, it stays high with `eng_ptr` stable until `eng_ready`. Only one transfer is outstanding at a time. `done_valid` is ignored while no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | N_CH | Request pulses, one per channel |
| ch_enable | input | N_CH | Per-channel enable |
| cfg_stop_on_err | input | 1 | Error outcomes also raise the global stop |
| ptr_wr_en | input | 1 | Pointer register write strobe |
| ptr_wr_idx | input | IDX_W | Channel written |
| ptr_wr_data | input | PTR_W | Pointer value written |
| sw_req | input | 1 | Software start request (level, drop after start accepted) |
| sw_ptr | input | PTR_W | Software descriptor pointer |
| eng_valid | output | 1 | Start offer to the engine |
| eng_ready | input | 1 | Engine accepts the start |
| eng_ptr | output | PTR_W | Descriptor pointer offered |
| eng_sw | output | 1 | Offer belongs to the software path |
| eng_ch | output | IDX_W | Hardware channel offered |
| done_valid | input | 1 | Outcome pulse of the running transfer |
| done_err | input | 1 | Outcome is an error |
| done_chain | input | 1 | Outcome is a chain |
| done_chain_lock | input | 1 | Chain runs on without releasing arbitration |
| done_irq | input | 1 | Descriptor asks for an interrupt flag |
| done_chain_ptr | input | PTR_W | Next descriptor pointer of a chain |
| done_info | input | INFO_W | Error detail code |
| mask_clr | input | N_CH | Write-1-to-clear of mask flags |
| irq_clr | input | N_CH | Write-1-to-clear of interrupt flags |
| err_clr | input | 1 | Clears error record and double bit |
| stop_clr | input | 1 | Clears the global stop |
| mask_flags | output | N_CH | Per-channel mask flags |
| irq_flags | output | N_CH | Per-channel interrupt flags |
| stop_flag | output | 1 | Global stop |
| err_valid | output | 1 | Error record occupied |
| err_double | output | 1 | A second error arrived while occupied |
| err_sw | output | 1 | Recorded error came from software |
| err_ch | output | IDX_W | Recorded hardware channel |
| err_info | output | INFO_W | Recorded error detail |

## Verification
The start offer rises two clock edges after a request pulse: one edge latches the request and one edge makes the selection. The bench therefore polls `eng_valid` on falling edges within a bounded window, rather than at a fixed offset. Flags and the error record change on the same edge that takes `done_valid`, so they are read at the next falling edge. A locked chain must show a new offer at exactly that falling edge, and the bench checks it there. Blocked starts (mask, stop, disabled channel) are confirmed by watching `eng_valid` stay low over several falling edges before the blocking condition is lifted.

// File: rtl/hss_pkg.sv
package hss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_BUSY  = 2'd2
  } hss_state_e;
endpackage

// File: rtl/hss_arbiter.sv
module hss_arbiter #(
  parameter int N_CH  = 4,
  parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]  req,
  output logic [N_CH-1:0]  grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N_CH:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < N_CH; g++) begin : g_chain
    assign grant[g]     = req[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req[g];
  end

  assign any = blocked[N_CH];

  always_comb begin
    idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant)); // R2
    AST_GRANT_IN_REQ: assert ((grant & ~req) == '0); // R2
  end
endmodule

// File: rtl/hss_ptr_store.sv
module hss_ptr_store #(
  parameter int N_CH  = 4,
  parameter int PTR_W = 16,
  parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             chain_upd,
  input  logic [PTR_W-1:0] chain_ptr,
  output logic [PTR_W-1:0] buf_ptr
);
  logic [PTR_W-1:0] ptr_q [N_CH];
  logic [PTR_W-1:0] buf_q;
  logic [IDX_W-1:0] buf_ch;
  logic             buf_vld;
  logic             hit;
  logic             wr_ok;
  logic             wr_hits_buf;

  assign hit         = buf_vld && (buf_ch == load_idx);
  assign wr_ok       = wr_en && (int'(wr_idx) < N_CH);
  assign wr_hits_buf = wr_ok && (wr_idx == buf_ch);
  assign buf_ptr     = buf_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
      end else if (wr_ok && (int'(wr_idx) == g)) begin
        ptr_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      buf_ch  <= '0;
      buf_vld <= 1'b0;
    end else begin
      if (load) begin
        if (!hit) buf_q <= ptr_q[load_idx];
        buf_ch  <= load_idx;
        buf_vld <= 1'b1;
      end else if (chain_upd) begin
        buf_q <= chain_ptr;
      end
      if (wr_ok && ((load && wr_idx == load_idx) || (!load && wr_hits_buf))) begin
        buf_vld <= 1'b0;
      end
    end
  end

  AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> buf_vld); // R3
  AST_WRITE_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !load && buf_vld && wr_idx == buf_ch) |=> !buf_vld); // R3
endmodule

// File: rtl/hss_status.sv
module hss_status #(
  parameter int N_CH   = 4,
  parameter int INFO_W = 8,
  parameter int IDX_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_err_evt,
  input  logic              sw_err_evt,
  input  logic              irq_evt,
  input  logic [IDX_W-1:0]  evt_ch,
  input  logic [INFO_W-1:0] evt_info,
  input  logic              stop_en,
  input  logic [N_CH-1:0]   mask_clr,
  input  logic [N_CH-1:0]   irq_clr,
  input  logic              err_clr,
  input  logic              stop_clr,
  output logic [N_CH-1:0]   mask_q,
  output logic [N_CH-1:0]   irq_q,
  output logic              stop_q,
  output logic              rec_vld_q,
  output logic              rec_dbl_q,
  output logic              rec_sw_q,
  output logic [IDX_W-1:0]  rec_ch_q,
  output logic [INFO_W-1:0] rec_info_q
);
  localparam logic [N_CH-1:0] ONE = N_CH'(1);

  logic [N_CH-1:0] ch_bit;
  logic            any_err;
  logic            rec_empty;

  assign ch_bit    = ONE << evt_ch;
  assign any_err   = hw_err_evt | sw_err_evt;
  assign rec_empty = !rec_vld_q || err_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      mask_q <= (mask_q & ~mask_clr) | (hw_err_evt ? ch_bit : '0);
      irq_q  <= (irq_q & ~irq_clr) | (irq_evt ? ch_bit : '0);
      if (any_err && stop_en) stop_q <= 1'b1;
      else if (stop_clr)      stop_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_vld_q  <= 1'b0;
      rec_dbl_q  <= 1'b0;
      rec_sw_q   <= 1'b0;
      rec_ch_q   <= '0;
      rec_info_q <= '0;
    end else begin
      if (err_clr) begin
        rec_vld_q <= 1'b0;
        rec_dbl_q <= 1'b0;
      end
      if (any_err) begin
        if (rec_empty) begin
          rec_vld_q  <= 1'b1;
          rec_sw_q   <= sw_err_evt;
          rec_ch_q   <= evt_ch;
          rec_info_q <= evt_info;
        end else begin
          rec_dbl_q <= 1'b1;
        end
      end
    end
  end

  AST_MASK_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err_evt |=> mask_q[$past(evt_ch)]); // R6
  AST_NO_IRQ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && irq_clr == '0) |=> irq_q == $past(irq_q)); // R5
  AST_DBL_NEEDS_REC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_dbl_q) |-> rec_vld_q); // R7
  AST_REC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_vld_q && !err_clr) |=> rec_vld_q && $stable(rec_info_q)); // R7
endmodule

// File: rtl/hss_top.sv
module hss_top #(
  parameter int N_CH   = 4,
  parameter int PTR_W  = 16,
  parameter int INFO_W = 8,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   hw_req,
  input  logic [N_CH-1:0]   ch_enable,
  input  logic              cfg_stop_on_err,
  input  logic              ptr_wr_en,
  input  logic [IDX_W-1:0]  ptr_wr_idx,
  input  logic [PTR_W-1:0]  ptr_wr_data,
  input  logic              sw_req,
  input  logic [PTR_W-1:0]  sw_ptr,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [PTR_W-1:0]  eng_ptr,
  output logic              eng_sw,
  output logic [IDX_W-1:0]  eng_ch,
  input  logic              done_valid,
  input  logic              done_err,
  input  logic              done_chain,
  input  logic              done_chain_lock,
  input  logic              done_irq,
  input  logic [PTR_W-1:0]  done_chain_ptr,
  input  logic [INFO_W-1:0] done_info,
  input  logic [N_CH-1:0]   mask_clr,
  input  logic [N_CH-1:0]   irq_clr,
  input  logic              err_clr,
  input  logic              stop_clr,
  output logic [N_CH-1:0]   mask_flags,
  output logic [N_CH-1:0]   irq_flags,
  output logic              stop_flag,
  output logic              err_valid,
  output logic              err_double,
  output logic              err_sw,
  output logic [IDX_W-1:0]  err_ch,
  output logic [INFO_W-1:0] err_info
);
  import hss_pkg::*;

  hss_state_e       state_q;
  logic [N_CH-1:0]  pend_q;
  logic [N_CH-1:0]  eligible;
  logic [N_CH-1:0]  grant;
  logic             any_elig;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] cur_ch_q;
  logic             cur_sw_q;
  logic [PTR_W-1:0] sw_ptr_q;
  logic [PTR_W-1:0] buf_ptr;

  logic idle_go;
  logic start_sw;
  logic start_hw;
  logic outcome;
  logic out_err;
  logic out_chain;
  logic hw_err_evt;
  logic sw_err_evt;
  logic irq_evt;
  logic chain_upd;

  assign eligible = pend_q & ch_enable & ~mask_flags & {N_CH{~stop_flag}};

  hss_arbiter #(.N_CH(N_CH), .IDX_W(IDX_W)) u_arb (
    .req  (eligible),
    .grant(grant),
    .any  (any_elig),
    .idx  (sel_idx)
  );

  assign idle_go  = (state_q == ST_IDLE) && !stop_flag;
  assign start_sw = idle_go && sw_req;
  assign start_hw = idle_go && !sw_req && any_elig;

  assign outcome    = (state_q == ST_BUSY) && done_valid;
  assign out_err    = outcome && done_err;
  assign out_chain  = outcome && !done_err && done_chain;
  assign hw_err_evt = out_err && !cur_sw_q;
  assign sw_err_evt = out_err && cur_sw_q;
  assign irq_evt    = outcome && !done_err && done_irq && !cur_sw_q;
  assign chain_upd  = out_chain && !cur_sw_q;

  hss_ptr_store #(.N_CH(N_CH), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ptr_wr_en),
    .wr_idx   (ptr_wr_idx),
    .wr_data  (ptr_wr_data),
    .load     (start_hw),
    .load_idx (sel_idx),
    .chain_upd(chain_upd),
    .chain_ptr(done_chain_ptr),
    .buf_ptr  (buf_ptr)
  );

  hss_status #(.N_CH(N_CH), .INFO_W(INFO_W), .IDX_W(IDX_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_err_evt(hw_err_evt),
    .sw_err_evt(sw_err_evt),
    .irq_evt   (irq_evt),
    .evt_ch    (cur_ch_q),
    .evt_info  (done_info),
    .stop_en   (cfg_stop_on_err),
    .mask_clr  (mask_clr),
    .irq_clr   (irq_clr),
    .err_clr   (err_clr),
    .stop_clr  (stop_clr),
    .mask_q    (mask_flags),
    .irq_q     (irq_flags),
    .stop_q    (stop_flag),
    .rec_vld_q (err_valid),
    .rec_dbl_q (err_double),
    .rec_sw_q  (err_sw),
    .rec_ch_q  (err_ch),
    .rec_info_q(err_info)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q | hw_req) & ~(start_hw ? grant : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_ch_q <= '0;
      cur_sw_q <= 1'b0;
      sw_ptr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_sw) begin
            cur_sw_q <= 1'b1;
            sw_ptr_q <= sw_ptr;
            state_q  <= ST_ISSUE;
          end else if (start_hw) begin
            cur_sw_q <= 1'b0;
            cur_ch_q <= sel_idx;
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (eng_ready) state_q <= ST_BUSY;
        end
        ST_BUSY: begin
          if (done_valid) begin
            if (out_chain && cur_sw_q) sw_ptr_q <= done_chain_ptr;
            if (out_chain && done_chain_lock) state_q <= ST_ISSUE;
            else                              state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign eng_valid = (state_q == ST_ISSUE);
  assign eng_sw    = cur_sw_q;
  assign eng_ch    = cur_ch_q;
  assign eng_ptr   = cur_sw_q ? sw_ptr_q : buf_ptr;

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_ready) |=> eng_valid && $stable(eng_ptr) && $stable(eng_ch)); // R11
  AST_NO_START_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> !stop_flag); // R8
  AST_NO_START_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_sw) |-> !mask_flags[eng_ch]); // R1
  AST_LOCK_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome && out_chain && done_chain_lock) |=> eng_valid && eng_ch == $past(eng_ch) && eng_sw == $past(eng_sw)); // R4
  AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_BUSY && done_valid && mask_clr == '0) |=> mask_flags == $past(mask_flags)); // R11
endmodule

// File: tb/hss_top_test.sv
module hss_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] hw_req = '0, ch_enable = '0, mask_clr = '0, irq_clr = '0;
  logic cfg_stop_on_err = 1'b0, ptr_wr_en = 1'b0, sw_req = 1'b0, eng_ready = 1'b0;
  logic [1:0] ptr_wr_idx = '0;
  logic [15:0] ptr_wr_data = '0, sw_ptr = '0, done_chain_ptr = '0;
  logic done_valid = 1'b0, done_err = 1'b0, done_chain = 1'b0, done_chain_lock = 1'b0, done_irq = 1'b0;
  logic [7:0] done_info = '0;
  logic err_clr = 1'b0, stop_clr = 1'b0;
  logic eng_valid, eng_sw, stop_flag, err_valid, err_double, err_sw;
  logic [15:0] eng_ptr;
  logic [1:0] eng_ch, err_ch;
  logic [N-1:0] mask_flags, irq_flags;
  logic [7:0] err_info;

  int total = 0;
  int bad = 0;
  logic [15:0] ptr_m [N];

  hss_top #(.N_CH(N), .PTR_W(16), .INFO_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .ch_enable(ch_enable),
    .cfg_stop_on_err(cfg_stop_on_err), .ptr_wr_en(ptr_wr_en), .ptr_wr_idx(ptr_wr_idx),
    .ptr_wr_data(ptr_wr_data), .sw_req(sw_req), .sw_ptr(sw_ptr),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_ptr(eng_ptr), .eng_sw(eng_sw),
    .eng_ch(eng_ch), .done_valid(done_valid), .done_err(done_err), .done_chain(done_chain),
    .done_chain_lock(done_chain_lock), .done_irq(done_irq), .done_chain_ptr(done_chain_ptr),
    .done_info(done_info), .mask_clr(mask_clr), .irq_clr(irq_clr), .err_clr(err_clr),
    .stop_clr(stop_clr), .mask_flags(mask_flags), .irq_flags(irq_flags), .stop_flag(stop_flag),
    .err_valid(err_valid), .err_double(err_double), .err_sw(err_sw), .err_ch(err_ch),
    .err_info(err_info)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] v);
    hw_req = v; @(negedge clk); hw_req = '0;
  endtask

  task automatic wptr(input int idx, input logic [15:0] d);
    ptr_wr_en = 1'b1; ptr_wr_idx = 2'(idx); ptr_wr_data = d;
    @(negedge clk);
    ptr_wr_en = 1'b0;
    ptr_m[idx] = d;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(eng_valid == 1'b0, tag, int'(eng_valid), 0);
    end
  endtask

  task automatic xfer(input int ech, input bit esw, input logic [15:0] eptr,
                      input bit err, input bit chain, input bit lock, input bit irq,
                      input logic [15:0] cptr, input logic [7:0] info, input string tag);
    int w = 0;
    while (!eng_valid && w < 20) begin
      @(negedge clk); w++;
    end
    chk(eng_valid == 1'b1, {tag, " start"}, int'(eng_valid), 1);
    if (eng_valid) begin
      chk(eng_sw == esw, {tag, " sw"}, int'(eng_sw), int'(esw));
      if (!esw) chk(int'(eng_ch) == ech, {tag, " ch"}, int'(eng_ch), ech);
      chk(eng_ptr == eptr, {tag, " ptr"}, int'(eng_ptr), int'(eptr));
      if (esw) sw_req = 1'b0;
      eng_ready = 1'b1;
      @(negedge clk);
      eng_ready = 1'b0;
      tick(1);
      done_valid = 1'b1; done_err = err; done_chain = chain; done_chain_lock = lock;
      done_irq = irq; done_chain_ptr = cptr; done_info = info;
      @(negedge clk);
      done_valid = 1'b0; done_err = 1'b0; done_chain = 1'b0; done_chain_lock = 1'b0; done_irq = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk(eng_valid == 0 && mask_flags == 0 && irq_flags == 0, "R10 reset flags", int'(mask_flags), 0);
    chk(err_valid == 0 && stop_flag == 0 && err_double == 0, "R10 reset record", int'(err_valid), 0);

    for (int i = 0; i < N; i++) wptr(i, 16'h1000 + 16'(i) * 16'h0111);

    // R1/R2 sweep over every enable set and request set
    for (int en = 0; en < 16; en++) begin
      for (int rq = 1; rq < 16; rq++) begin
        ch_enable = 4'(en);
        pulse_req(4'(rq));
        for (int c = 0; c < N; c++)
          if (rq[c] && en[c]) xfer(c, 0, ptr_m[c], 0, 0, 0, 0, 16'h0, 8'h0, "R2 order");
        quiet(3, "R1 disabled held");
        ch_enable = 4'hF;
        for (int c = 0; c < N; c++)
          if (rq[c] && !en[c]) xfer(c, 0, ptr_m[c], 0, 0, 0, 0, 16'h0, 8'h0, "R1 released");
      end
    end

    // R3 buffer reuse and invalidation
    pulse_req(4'b0100);
    xfer(2, 0, ptr_m[2], 0, 1, 0, 0, 16'hBEEF, 8'h0, "R3 chain unlocked");
    pulse_req(4'b0100);
    xfer(2, 0, 16'hBEEF, 0, 0, 0, 0, 16'h0, 8'h0, "R3 buffer reused");
    wptr(2, 16'h2222);
    pulse_req(4'b0100);
    xfer(2, 0, 16'h2222, 0, 0, 0, 0, 16'h0, 8'h0, "R3 invalidated");

    // R4 locked chain overtakes pending channel 0
    pulse_req(4'b1000);
    tick(3);
    pulse_req(4'b0001);
    xfer(3, 0, ptr_m[3], 0, 1, 1, 0, 16'h3333, 8'h0, "R4 first");
    chk(eng_valid == 1 && eng_ch == 2'd3 && eng_ptr == 16'h3333, "R4 reissue next cycle", int'(eng_ptr), 16'h3333);
    xfer(3, 0, 16'h3333, 0, 0, 0, 0, 16'h0, 8'h0, "R4 chained");
    xfer(0, 0, ptr_m[0], 0, 0, 0, 0, 16'h0, 8'h0, "R4 then pending");

    // R11 stray outcome while idle
    done_valid = 1'b1; done_err = 1'b1; @(negedge clk); done_valid = 1'b0; done_err = 1'b0;
    tick(1);
    chk(err_valid == 0 && mask_flags == 0, "R11 idle done ignored", int'(mask_flags), 0);

    // R5 interrupt on normal end, not on error; R6/R7 first error
    pulse_req(4'b0010);
    xfer(1, 0, ptr_m[1], 0, 0, 0, 1, 16'h0, 8'h0, "R5 irq");
    chk(irq_flags == 4'b0010, "R5 irq set", int'(irq_flags), 2);
    pulse_req(4'b0001);
    xfer(0, 0, ptr_m[0], 1, 0, 0, 1, 16'h0, 8'h5A, "R6 err ch0");
    chk(irq_flags == 4'b0010, "R5 no irq on error", int'(irq_flags), 2);
    chk(mask_flags == 4'b0001, "R6 mask set", int'(mask_flags), 1);
    chk(err_valid && !err_double && err_info == 8'h5A && err_ch == 0 && !err_sw, "R7 record", int'(err_info), 16'h5A);
    irq_clr = 4'b0010; @(negedge clk); irq_clr = '0;
    chk(irq_flags == 0, "R10 irq clear", int'(irq_flags), 0);

    pulse_req(4'b0001);
    quiet(6, "R1 masked held");
    pulse_req(4'b0100);
    xfer(2, 0, ptr_m[2], 1, 0, 0, 0, 16'h0, 8'h77, "R7 second err");
    chk(err_double == 1 && err_info == 8'h5A && err_ch == 0, "R7 double kept", int'(err_info), 16'h5A);
    chk(mask_flags == 4'b0101, "R6 mask two", int'(mask_flags), 5);

    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(err_valid == 0 && err_double == 0, "R10 record clear", int'(err_valid), 0);
    mask_clr = 4'b0001; @(negedge clk); mask_clr = '0;
    xfer(0, 0, ptr_m[0], 0, 0, 0, 0, 16'h0, 8'h0, "R10 unmasked pending");
    mask_clr = 4'b0100; @(negedge clk); mask_clr = '0;
    chk(mask_flags == 0, "R10 mask clear", int'(mask_flags), 0);

    // R8 global stop holds hardware and software
    cfg_stop_on_err = 1'b1;
    pulse_req(4'b0010);
    xfer(1, 0, ptr_m[1], 1, 0, 0, 0, 16'h0, 8'h11, "R8 err");
    chk(stop_flag == 1, "R8 stop set", int'(stop_flag), 1);
    sw_ptr = 16'hA5A5; sw_req = 1'b1;
    pulse_req(4'b1000);
    quiet(8, "R8 stop holds");
    err_clr = 1'b1; stop_clr = 1'b1; @(negedge clk); err_clr = 1'b0; stop_clr = 1'b0;
    xfer(0, 1, 16'hA5A5, 1, 0, 0, 0, 16'h0, 8'h3C, "R9 sw first");
    chk(err_valid && err_sw && err_info == 8'h3C, "R9 sw err recorded", int'(err_info), 16'h3C);
    chk(stop_flag == 1 && mask_flags == 4'b0010, "R9 sw err stop, no mask", int'(mask_flags), 2);
    cfg_stop_on_err = 1'b0;
    stop_clr = 1'b1; mask_clr = 4'b0010; @(negedge clk); stop_clr = 1'b0; mask_clr = '0;
    xfer(3, 0, ptr_m[3], 0, 0, 0, 0, 16'h0, 8'h0, "R8 released");

    // R9 simultaneous software and hardware, software chain locked
    sw_ptr = 16'h5000; sw_req = 1'b1; hw_req = 4'b0001;
    @(negedge clk); hw_req = '0;
    xfer(0, 1, 16'h5000, 0, 1, 1, 0, 16'hC0DE, 8'h0, "R9 sw wins");
    xfer(0, 1, 16'hC0DE, 0, 0, 0, 0, 16'h0, 8'h0, "R9 sw chained");
    xfer(0, 0, ptr_m[0], 0, 0, 0, 0, 16'h0, 8'h0, "R9 hw after");
    quiet(3, "R11 single outstanding");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule